// File: doc/BRIEF.md
# Smart Card Transmit-End Flag Timer

This block drives the transmit-end status flag of a half-duplex smart card transmitter. Each character begins with a one-cycle start pulse. From that pulse the block counts clock cycles in half elementary-time-unit (etu) steps. At a set point chosen by the guard-time and block mode bits, it raises the flag. The flag rises only when the card signalled no parity error during the character and the next byte is already waiting, which is shown by the data-register-empty status being 1.

Software clears the flag by reading it as 1 and then writing 0. A transfer engine can also clear it by loading the next byte. The block makes a transfer request for that engine. In byte mode the request follows the flag, and in block mode it follows the data-register-empty status. When both enables are low the flag is held at 1. Serialisation, parity and baud-rate generation sit outside this block.

Top module: `sc_tend_timer`

## Requirements
- R1: After reset `tend` is 1, and with `tx_en` = 0 `xfer_req` is 0.
- R2: While `tx_en` and `aux_en` are both 0, `tend` is 1 from the next cycle onward.
- R3: With `guard_mode` = 0 and `block_mode` = 0, `tend` rises 5×(ETU_CYCLES/2) cycles after the clock edge that samples `char_start`.
- R4: With `guard_mode` = 0 and `block_mode` = 1, `tend` rises 3×(ETU_CYCLES/2) cycles after that edge.
- R5: With `guard_mode` = 1, `tend` rises ETU_CYCLES cycles after that edge, for either value of `block_mode`.
- R6: If `err_sig` is 1 in any cycle of the character window, `tend` is not set for that character.
- R7: If `tdr_empty` is 0 at the set point, `tend` is not set.
- R8: A bus write with `wr_data` = 0 clears `tend` only if `tend` was read as 1 (`rd_strobe`) since the last character start. A write with `wr_data` = 1 has no effect, and neither does a write of 0 with no prior read.
- R9: A `dtc_wr` pulse clears `tend` on the next edge.
- R10: `xfer_req` equals `tend` when `block_mode` = 0 and equals `tdr_empty` when `block_mode` = 1, gated by `tx_en`. A `dma_wr` clears `tend` only while `xfer_req` is 1.
- R11: A `char_start` pulse drops a pending read, so a later write of 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| aux_en | input | 1 | Companion enable |
| guard_mode | input | 1 | Guard-time mode select |
| block_mode | input | 1 | Block transfer mode select |
| char_start | input | 1 | One-cycle pulse at character start |
| err_sig | input | 1 | Error signal seen from the card |
| tdr_empty | input | 1 | Transmit data register empty |
| rd_strobe | input | 1 | Bus read of the flag |
| wr_strobe | input | 1 | Bus write of the flag |
| wr_data | input | 1 | Value written to the flag |
| dtc_wr | input | 1 | Interrupt-driven hardware write of the next byte |
| dma_wr | input | 1 | Data-transfer write of the next byte |
| tend | output | 1 | Transmit-end flag |
| xfer_req | output | 1 | Data-transfer trigger request |

## Verification
The flag is a single register. It rises a set number of cycles after the edge that samples `char_start`: 20, 12 or 8 cycles with ETU_CYCLES = 8. A clear takes effect one edge after its strobe, and `xfer_req` follows its inputs within the same cycle. The bench drives inputs and samples outputs on falling edges. For each timing case it checks the flag as still 0 one cycle before the expected edge and as 1 just after it, so a set point one cycle early or late is reported. Each clear and blocking case is checked one cycle after its strobe, before anything else can move the flag.

// File: rtl/sc_tend_timer.sv
module sc_tend_timer #(
  parameter int ETU_CYCLES = 372
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic aux_en,
  input  logic guard_mode,
  input  logic block_mode,
  input  logic char_start,
  input  logic err_sig,
  input  logic tdr_empty,
  input  logic rd_strobe,
  input  logic wr_strobe,
  input  logic wr_data,
  input  logic dtc_wr,
  input  logic dma_wr,
  output logic tend,
  output logic xfer_req
);
  // ETU_CYCLES must be even so that a half etu is a whole number of cycles
  localparam int HALF  = ETU_CYCLES / 2;
  localparam int T_ONE = 2 * HALF;
  localparam int T_BLK = 3 * HALF;
  localparam int T_STD = 5 * HALF;
  localparam int CW    = $clog2(T_STD + 1);

  logic [CW-1:0] cyc;
  logic [CW-1:0] target;
  logic          run;
  logic          err_seen;
  logic          rd_arm;
  logic          enabled;
  logic          hit;
  logic          ok;
  logic          sw_clr;
  logic          clr;

  assign enabled  = tx_en | aux_en;
  assign target   = guard_mode ? CW'(T_ONE - 1) :
                    block_mode ? CW'(T_BLK - 1) : CW'(T_STD - 1);
  assign hit      = run & ~char_start & (cyc == target);
  assign ok       = ~err_seen & ~err_sig & tdr_empty;
  assign xfer_req = tx_en & (block_mode ? tdr_empty : tend);
  assign sw_clr   = wr_strobe & ~wr_data & rd_arm;
  assign clr      = dtc_wr | (dma_wr & xfer_req) | sw_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cyc <= '0;
    end else if (char_start) begin
      run <= 1'b1;
      cyc <= '0;
    end else if (hit) begin
      run <= 1'b0;
    end else if (run) begin
      cyc <= cyc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          err_seen <= 1'b0;
    else if (char_start) err_seen <= 1'b0;
    else if (run && err_sig) err_seen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rd_arm <= 1'b0;
    else if (char_start || sw_clr) rd_arm <= 1'b0;
    else if (rd_strobe && tend)  rd_arm <= 1'b1;
  end

  // the set point wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tend <= 1'b1;
    else if (!enabled)  tend <= 1'b1;
    else if (hit && ok) tend <= 1'b1;
    else if (clr)       tend <= 1'b0;
  end
endmodule

module sc_tend_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic aux_en,
  input logic tdr_empty,
  input logic err_sig,
  input logic wr_strobe,
  input logic wr_data,
  input logic dtc_wr,
  input logic dma_wr,
  input logic xfer_req,
  input logic err_seen,
  input logic hit,
  input logic tend
);
  // R2
  disabled_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !aux_en) |=> tend);

  // R6
  err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_en || aux_en) && !tend && (err_seen || err_sig)) |=> !tend);

  // R7
  not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_en || aux_en) && !tend && !tdr_empty) |=> !tend);

  // R9
  dtc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_en || aux_en) && dtc_wr && !hit) |=> !tend);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_en || aux_en) && tend && !dtc_wr && !(dma_wr && xfer_req)
      && !(wr_strobe && !wr_data)) |=> tend);
endmodule

bind sc_tend_timer sc_tend_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .aux_en(aux_en),
  .tdr_empty(tdr_empty), .err_sig(err_sig), .wr_strobe(wr_strobe),
  .wr_data(wr_data), .dtc_wr(dtc_wr), .dma_wr(dma_wr),
  .xfer_req(xfer_req), .err_seen(err_seen), .hit(hit), .tend(tend)
);

// File: tb/sc_tend_timer_bench.sv
module sc_tend_timer_bench;
  localparam int ETU = 8;
  localparam int H   = ETU / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, aux_en = 0, guard_mode = 0, block_mode = 0;
  logic char_start = 0, err_sig = 0, tdr_empty = 1;
  logic rd_strobe = 0, wr_strobe = 0, wr_data = 0, dtc_wr = 0, dma_wr = 0;
  logic tend, xfer_req;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  sc_tend_timer #(.ETU_CYCLES(ETU)) u_sc_tend_timer (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .aux_en(aux_en),
    .guard_mode(guard_mode), .block_mode(block_mode), .char_start(char_start),
    .err_sig(err_sig), .tdr_empty(tdr_empty), .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .dtc_wr(dtc_wr), .dma_wr(dma_wr),
    .tend(tend), .xfer_req(xfer_req)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic clear_by_dtc();
    pulse(dtc_wr);
  endtask

  task automatic timed_set(input string req, input logic g, input logic b, input int cyc);
    guard_mode = g; block_mode = b;
    clear_by_dtc();
    chk({req, " cleared before start"}, tend, 1'b0);
    pulse(char_start);
    repeat (cyc - 1) @(negedge clk);
    chk({req, " not yet set"}, tend, 1'b0);
    @(negedge clk);
    chk({req, " set on time"}, tend, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 tend after reset", tend, 1'b1);
    chk("R1 xfer_req after reset", xfer_req, 1'b0);
  endtask

  task automatic t_disabled();
    tx_en = 1;
    clear_by_dtc();
    chk("R9 dtc clears", tend, 1'b0);
    @(negedge clk) tx_en = 0;
    @(negedge clk);
    chk("R2 disabled forces 1", tend, 1'b1);
    tx_en = 1;
  endtask

  task automatic t_blocked(input string req, input logic use_err);
    guard_mode = 0; block_mode = 0;
    clear_by_dtc();
    pulse(char_start);
    repeat (3) @(negedge clk);
    if (use_err) pulse(err_sig);
    else tdr_empty = 0;
    repeat (5 * H + 4) @(negedge clk);
    chk(req, tend, 1'b0);
    tdr_empty = 1;
  endtask

  task automatic t_sw_clear();
    chk("R8 flag high before writes", tend, 1'b1);
    wr_data = 0; pulse(wr_strobe);
    chk("R8 write 0 without read ignored", tend, 1'b1);
    pulse(rd_strobe);
    wr_data = 1; pulse(wr_strobe);
    chk("R8 write 1 ignored", tend, 1'b1);
    wr_data = 0; pulse(wr_strobe);
    chk("R8 write 0 after read clears", tend, 1'b0);
  endtask

  task automatic t_arm_drop();
    guard_mode = 1; block_mode = 0;
    // tend is 1 from the previous set; arm, then start a new character
    pulse(rd_strobe);
    pulse(char_start);
    wr_data = 0; pulse(wr_strobe);
    chk("R11 start drops read arm", tend, 1'b1);
    repeat (2 * H + 2) @(negedge clk);
  endtask

  task automatic t_xfer();
    block_mode = 0;
    @(negedge clk);
    chk("R10 byte mode req follows tend", xfer_req, tend);
    block_mode = 1; tdr_empty = 0;
    @(negedge clk);
    chk("R10 block mode req follows tdr_empty", xfer_req, 1'b0);
    pulse(dma_wr);
    chk("R10 dma without req ignored", tend, 1'b1);
    block_mode = 0; tdr_empty = 1;
    pulse(dma_wr);
    chk("R10 dma with req clears", tend, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_disabled();
    timed_set("R3", 1'b0, 1'b0, 5 * H);
    timed_set("R4", 1'b0, 1'b1, 3 * H);
    timed_set("R5 blk0", 1'b1, 1'b0, 2 * H);
    timed_set("R5 blk1", 1'b1, 1'b1, 2 * H);
    t_blocked("R6 error blocks set", 1'b1);
    t_blocked("R7 not empty blocks set", 1'b0);
    timed_set("R3 again", 1'b0, 1'b0, 5 * H);
    t_sw_clear();
    timed_set("R5 rearm", 1'b1, 1'b0, 2 * H);
    t_arm_drop();
    t_xfer();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule